// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Swap-Back Side Buffer

This block is a read-only data cache that sits between a processor load port and a slower line-oriented memory. Its main storage is direct mapped: every byte address selects exactly one line slot. Any line pushed out of that slot by a refill is not thrown away. It is parked in a small, fully associative side buffer, and every entry of that buffer is compared at once against each lookup.

A request that misses the main array but finds its line in the side buffer is served without any memory traffic. The two lines trade places: the wanted line goes into the main slot, and the line it displaces takes over the side entry that was freed. Only a miss in both structures starts a fixed-length burst on the memory port. The requested word is returned when the last beat arrives. Two addresses that share an index therefore stop thrashing each other after their first two references.

The block accepts one request at a time. `req_ready` shows when a new address can be taken. Each answer is a one-cycle `rsp_valid` pulse with the data word and flags that tell which structure supplied it.

Top module: `swap_cache`

## Requirements
- R1: After reset no line is valid in either structure: `req_ready` is 1, `rsp_valid` is 0, and the first access to any address is a refill.
- R2: With default parameters the address splits into byte offset [4:0], line index [9:5] and tag [31:10]. Bits [4:2] select one of eight 32-bit words in the line.
- R3: A request whose index slot is valid with an equal tag is answered with `rsp_hit`=1 and `rsp_side`=0 and no memory burst. `rsp_valid` rises in the second cycle after the request is accepted.
- R4: A request that misses both structures raises `mem_req` with `mem_addr` set to the line-aligned address. It takes 8 beats in which beat k carries word k, and answers after the last beat with `rsp_hit`=0 and `rsp_side`=0.
- R5: When a refill replaces a valid main-array line, that line is written into the side buffer.
- R6: A request that misses the main array but matches a side entry is answered with `rsp_side`=1 and no memory burst. The requested line moves into the main array and the displaced main line takes that side entry.
- R7: Refill pushes into the side buffer follow first-in first-out order, so with 4 entries the fifth push overwrites the oldest line.
- R8: Two lines that alternate on one index are, after their first two misses, served from the side buffer on every further access.
- R9: While a request is in progress `req_ready` is 0 and a held `req_valid` is ignored.
- R10: `rsp_valid` is a single-cycle pulse, and `rsp_hit` and `rsp_side` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | 32 | Byte address of the request |
| req_ready | output | 1 | Block can accept a request this cycle |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 32 | Addressed word |
| rsp_hit | output | 1 | Served from the main array |
| rsp_side | output | 1 | Served from the side buffer after a swap |
| mem_req | output | 1 | Line fetch in progress |
| mem_addr | output | 32 | Line-aligned fetch address |
| mem_rvalid | input | 1 | Refill beat valid |
| mem_rdata | input | 32 | Refill beat data |

## Verification
The bench builds the block with its defaults: 32 lines of 32 bytes and four side entries. Random addresses are limited to six tags over eight indices, so main hits, swaps and refills all occur often. The side buffer fills and wraps many times, which makes FIFO overwrite and lines moving repeatedly between the two structures reachable in a short run. Directed sequences pin down ping-pong conflicts, the fifth-push overwrite and a request held high during a burst.

// File: rtl/swc_pkg.sv
package swc_pkg;
   localparam int unsigned WORD_BITS = 32;

   typedef enum logic [1:0] {
      CS_IDLE  = 2'd0,
      CS_PROBE = 2'd1,
      CS_BURST = 2'd2
   } cs_state_e;
endpackage

// File: rtl/swap_cache_line_store.sv
module swap_cache_line_store #(
   parameter int unsigned SETS   = 32,
   parameter int unsigned TAG_W  = 22,
   parameter int unsigned LINE_W = 256,
   localparam int unsigned IDX_W = (SETS > 1) ? $clog2(SETS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_valid,
   output logic [TAG_W-1:0]  rd_tag,
   output logic [LINE_W-1:0] rd_line,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [LINE_W-1:0] wr_line
);
   logic [SETS-1:0]   valid_q;
   logic [TAG_W-1:0]  tag_q  [SETS];
   logic [LINE_W-1:0] line_q [SETS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q <= '0;
      else if (wr_en) valid_q[wr_idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx]  <= wr_tag;
         line_q[wr_idx] <= wr_line;
      end
   end

   assign rd_valid = valid_q[rd_idx];
   assign rd_tag   = tag_q[rd_idx];
   assign rd_line  = line_q[rd_idx];

   // R4: a written slot reads back valid with the written tag
   p_store_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (valid_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag)));
endmodule

// File: rtl/swap_cache_side_buf.sv
module swap_cache_side_buf #(
   parameter int unsigned ENTRIES = 4,
   parameter int unsigned LA_W    = 27,
   parameter int unsigned LINE_W  = 256,
   localparam int unsigned SEL_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LA_W-1:0]   look_la,
   output logic              hit,
   output logic [SEL_W-1:0]  hit_sel,
   output logic [LINE_W-1:0] hit_line,
   input  logic              swap_en,
   input  logic [SEL_W-1:0]  swap_sel,
   input  logic              swap_valid,
   input  logic [LA_W-1:0]   swap_la,
   input  logic [LINE_W-1:0] swap_line,
   input  logic              push_en,
   input  logic [LA_W-1:0]   push_la,
   input  logic [LINE_W-1:0] push_line
);
   logic [ENTRIES-1:0] v_q;
   logic [LA_W-1:0]    la_q   [ENTRIES];
   logic [LINE_W-1:0]  line_q [ENTRIES];
   logic [ENTRIES-1:0] match;
   logic [SEL_W-1:0]   ptr_q, ptr_nx;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign match[e] = v_q[e] && (la_q[e] == look_la);
   end

   always_comb begin
      hit_sel = '0;
      for (int e = ENTRIES - 1; e >= 0; e--) begin
         if (match[e]) hit_sel = SEL_W'(e);
      end
   end
   assign hit      = |match;
   assign hit_line = line_q[hit_sel];

   if (ENTRIES > 1) begin : g_ring
      assign ptr_nx = (ptr_q == SEL_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
   end else begin : g_single
      assign ptr_nx = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q   <= '0;
         ptr_q <= '0;
      end else begin
         for (int e = 0; e < ENTRIES; e++) begin
            if (swap_en && swap_sel == SEL_W'(e)) v_q[e] <= swap_valid;
            else if (push_en && ptr_q == SEL_W'(e)) v_q[e] <= 1'b1;
         end
         if (push_en) ptr_q <= ptr_nx;
      end
   end

   always_ff @(posedge clk) begin
      for (int e = 0; e < ENTRIES; e++) begin
         if (swap_en && swap_sel == SEL_W'(e)) begin
            la_q[e]   <= swap_la;
            line_q[e] <= swap_line;
         end else if (push_en && ptr_q == SEL_W'(e)) begin
            la_q[e]   <= push_la;
            line_q[e] <= push_line;
         end
      end
   end

   // R6: a line address never sits in two side entries
   p_side_unique_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));
   // R5: a swap and a push never target the buffer in the same cycle
   p_push_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(swap_en && push_en));
   // R7: the push pointer moves by exactly one entry per push
   p_fifo_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !push_en |=> $stable(ptr_q));
endmodule

// File: rtl/swap_cache_fsm.sv
module swap_cache_fsm
   import swc_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned OFF_W  = 5,
   parameter int unsigned IDX_W  = 5,
   parameter int unsigned WORDS  = 8,
   parameter int unsigned SEL_W  = 2,
   localparam int unsigned TAG_W  = ADDR_W - OFF_W - IDX_W,
   localparam int unsigned LA_W   = ADDR_W - OFF_W,
   localparam int unsigned LINE_W = WORDS * WORD_BITS,
   localparam int unsigned WSEL_W = (OFF_W > 2) ? OFF_W - 2 : 1,
   localparam int unsigned BEAT_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic [WORD_BITS-1:0] rsp_data,
   output logic              rsp_hit,
   output logic              rsp_side,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [WORD_BITS-1:0] mem_rdata,
   output logic [IDX_W-1:0]  st_rd_idx,
   input  logic              st_rd_valid,
   input  logic [TAG_W-1:0]  st_rd_tag,
   input  logic [LINE_W-1:0] st_rd_line,
   output logic              st_wr_en,
   output logic [IDX_W-1:0]  st_wr_idx,
   output logic [TAG_W-1:0]  st_wr_tag,
   output logic [LINE_W-1:0] st_wr_line,
   output logic [LA_W-1:0]   sb_look_la,
   input  logic              sb_hit,
   input  logic [SEL_W-1:0]  sb_hit_sel,
   input  logic [LINE_W-1:0] sb_hit_line,
   output logic              sb_swap_en,
   output logic [SEL_W-1:0]  sb_swap_sel,
   output logic              sb_swap_valid,
   output logic [LA_W-1:0]   sb_swap_la,
   output logic [LINE_W-1:0] sb_swap_line,
   output logic              sb_push_en,
   output logic [LA_W-1:0]   sb_push_la,
   output logic [LINE_W-1:0] sb_push_line
);
   cs_state_e         state_q;
   logic [LA_W-1:0]   la_q;
   logic [WSEL_W-1:0] wsel_q;
   logic [BEAT_W-1:0] beat_q;
   logic [LINE_W-1:0] fill_q, fill_line;
   logic [TAG_W-1:0]  tag_q;
   logic [IDX_W-1:0]  idx_q;
   logic main_hit, side_take, fill_done;

   assign tag_q = la_q[LA_W-1:IDX_W];
   assign idx_q = la_q[IDX_W-1:0];

   assign req_ready = (state_q == CS_IDLE);
   assign mem_req   = (state_q == CS_BURST);
   assign mem_addr  = {la_q, {OFF_W{1'b0}}};

   assign main_hit  = st_rd_valid && (st_rd_tag == tag_q);
   assign side_take = (state_q == CS_PROBE) && !main_hit && sb_hit;
   assign fill_done = (state_q == CS_BURST) && mem_rvalid &&
                      (beat_q == BEAT_W'(WORDS - 1));

   always_comb begin
      fill_line = fill_q;
      fill_line[int'(beat_q) * WORD_BITS +: WORD_BITS] = mem_rdata;
   end

   assign st_rd_idx  = idx_q;
   assign st_wr_en   = side_take || fill_done;
   assign st_wr_idx  = idx_q;
   assign st_wr_tag  = tag_q;
   assign st_wr_line = (state_q == CS_PROBE) ? sb_hit_line : fill_line;

   assign sb_look_la    = la_q;
   assign sb_swap_en    = side_take;
   assign sb_swap_sel   = sb_hit_sel;
   assign sb_swap_valid = st_rd_valid;
   assign sb_swap_la    = {st_rd_tag, idx_q};
   assign sb_swap_line  = st_rd_line;
   assign sb_push_en    = fill_done && st_rd_valid;
   assign sb_push_la    = {st_rd_tag, idx_q};
   assign sb_push_line  = st_rd_line;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= CS_IDLE;
         la_q      <= '0;
         wsel_q    <= '0;
         beat_q    <= '0;
         fill_q    <= '0;
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
         rsp_hit   <= 1'b0;
         rsp_side  <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         unique case (state_q)
            CS_IDLE: begin
               if (req_valid) begin
                  la_q    <= req_addr[ADDR_W-1:OFF_W];
                  wsel_q  <= req_addr[OFF_W-1:2];
                  state_q <= CS_PROBE;
               end
            end
            CS_PROBE: begin
               if (main_hit) begin
                  rsp_valid <= 1'b1;
                  rsp_hit   <= 1'b1;
                  rsp_side  <= 1'b0;
                  rsp_data  <= st_rd_line[int'(wsel_q) * WORD_BITS +: WORD_BITS];
                  state_q   <= CS_IDLE;
               end else if (sb_hit) begin
                  rsp_valid <= 1'b1;
                  rsp_hit   <= 1'b0;
                  rsp_side  <= 1'b1;
                  rsp_data  <= sb_hit_line[int'(wsel_q) * WORD_BITS +: WORD_BITS];
                  state_q   <= CS_IDLE;
               end else begin
                  beat_q  <= '0;
                  state_q <= CS_BURST;
               end
            end
            CS_BURST: begin
               if (mem_rvalid) begin
                  fill_q <= fill_line;
                  beat_q <= beat_q + 1'b1;
                  if (fill_done) begin
                     rsp_valid <= 1'b1;
                     rsp_hit   <= 1'b0;
                     rsp_side  <= 1'b0;
                     rsp_data  <= fill_line[int'(wsel_q) * WORD_BITS +: WORD_BITS];
                     state_q   <= CS_IDLE;
                  end
               end
            end
            default: state_q <= CS_IDLE;
         endcase
      end
   end

   // R10: answers are exclusive and last one cycle
   p_rsp_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !(rsp_hit && rsp_side));
   p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   // R3: a main-array hit never starts a burst
   p_hit_nomem_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == CS_PROBE && main_hit) |=> !mem_req);
   // R6: a side-buffer hit never starts a burst
   p_side_nomem_r6: assert property (@(posedge clk) disable iff (!rst_n)
      side_take |=> !mem_req);
   // R4: the fetch address holds for the whole burst and the burst ends on the last beat
   p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !fill_done) |=> (mem_req && $stable(mem_addr)));
   p_fill_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fill_done |=> (!mem_req && rsp_valid));
   // R9: an answer only follows a busy cycle
   p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(!req_ready));
endmodule

// File: rtl/swap_cache.sv
module swap_cache #(
   parameter int unsigned ADDR_W       = 32,
   parameter int unsigned LINE_BYTES   = 32,
   parameter int unsigned LINES        = 32,
   parameter int unsigned SIDE_ENTRIES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic [31:0]       rsp_data,
   output logic              rsp_hit,
   output logic              rsp_side,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [31:0]       mem_rdata
);
   localparam int unsigned OFF_W  = $clog2(LINE_BYTES);
   localparam int unsigned IDX_W  = (LINES > 1) ? $clog2(LINES) : 1;
   localparam int unsigned TAG_W  = ADDR_W - OFF_W - IDX_W;
   localparam int unsigned LA_W   = ADDR_W - OFF_W;
   localparam int unsigned WORDS  = LINE_BYTES / 4;
   localparam int unsigned LINE_W = WORDS * swc_pkg::WORD_BITS;
   localparam int unsigned SEL_W  = (SIDE_ENTRIES > 1) ? $clog2(SIDE_ENTRIES) : 1;

   initial begin
      assert (LINE_BYTES >= 8 && (1 << OFF_W) == LINE_BYTES)
         else $error("line size must be a power of two of at least 8 bytes");
      assert (LINES >= 2 && (1 << IDX_W) == LINES)
         else $error("line count must be a power of two of at least 2");
      assert (SIDE_ENTRIES >= 1) else $error("side buffer needs an entry");
      assert (ADDR_W > OFF_W + IDX_W) else $error("address too narrow");
   end

   logic              st_rd_valid, st_wr_en;
   logic [IDX_W-1:0]  st_rd_idx, st_wr_idx;
   logic [TAG_W-1:0]  st_rd_tag, st_wr_tag;
   logic [LINE_W-1:0] st_rd_line, st_wr_line;
   logic [LA_W-1:0]   sb_look_la, sb_swap_la, sb_push_la;
   logic              sb_hit, sb_swap_en, sb_swap_valid, sb_push_en;
   logic [SEL_W-1:0]  sb_hit_sel, sb_swap_sel;
   logic [LINE_W-1:0] sb_hit_line, sb_swap_line, sb_push_line;

   swap_cache_line_store #(.SETS(LINES), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_store (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(st_rd_idx), .rd_valid(st_rd_valid), .rd_tag(st_rd_tag), .rd_line(st_rd_line),
      .wr_en(st_wr_en), .wr_idx(st_wr_idx), .wr_tag(st_wr_tag), .wr_line(st_wr_line)
   );

   swap_cache_side_buf #(.ENTRIES(SIDE_ENTRIES), .LA_W(LA_W), .LINE_W(LINE_W)) u_side (
      .clk(clk), .rst_n(rst_n),
      .look_la(sb_look_la), .hit(sb_hit), .hit_sel(sb_hit_sel), .hit_line(sb_hit_line),
      .swap_en(sb_swap_en), .swap_sel(sb_swap_sel), .swap_valid(sb_swap_valid),
      .swap_la(sb_swap_la), .swap_line(sb_swap_line),
      .push_en(sb_push_en), .push_la(sb_push_la), .push_line(sb_push_line)
   );

   swap_cache_fsm #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W),
                    .WORDS(WORDS), .SEL_W(SEL_W)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_hit(rsp_hit), .rsp_side(rsp_side),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .st_rd_idx(st_rd_idx), .st_rd_valid(st_rd_valid), .st_rd_tag(st_rd_tag),
      .st_rd_line(st_rd_line), .st_wr_en(st_wr_en), .st_wr_idx(st_wr_idx),
      .st_wr_tag(st_wr_tag), .st_wr_line(st_wr_line),
      .sb_look_la(sb_look_la), .sb_hit(sb_hit), .sb_hit_sel(sb_hit_sel),
      .sb_hit_line(sb_hit_line), .sb_swap_en(sb_swap_en), .sb_swap_sel(sb_swap_sel),
      .sb_swap_valid(sb_swap_valid), .sb_swap_la(sb_swap_la), .sb_swap_line(sb_swap_line),
      .sb_push_en(sb_push_en), .sb_push_la(sb_push_la), .sb_push_line(sb_push_line)
   );
endmodule

// File: tb/swap_cache_tb.sv
`timescale 1ns/1ps
module swap_cache_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        req_ready, rsp_valid, rsp_hit, rsp_side, mem_req;
   logic [31:0] rsp_data, mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;

   int checks = 0;
   int fails  = 0;
   int fills  = 0;
   bit done   = 0;
   logic [31:0] last_fill_addr = '0;
   int last_kind = -1;

   // bench model state
   bit          m_v  [32];
   logic [21:0] m_t  [32];
   bit          s_v  [4];
   logic [26:0] s_la [4];
   int          s_ptr = 0;

   always #2 clk = ~clk;

   swap_cache u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .rsp_hit(rsp_hit), .rsp_side(rsp_side), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      logic [31:0] w;
      w = {a[31:2], 2'b00};
      return (w * 32'h9E37_79B1) ^ 32'h1234_5678;
   endfunction

   function automatic logic [31:0] mk(input int tag, input int idx, input int off);
      return {22'(tag), 5'(idx), 5'(off)};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // 0 = main hit, 1 = side hit, 2 = refill
   task automatic model_step(input logic [31:0] a, output int kind);
      logic [4:0]  ix;
      logic [21:0] tg;
      int j;
      ix = a[9:5]; tg = a[31:10];
      j = -1;
      if (m_v[ix] && m_t[ix] == tg) kind = 0;
      else begin
         for (int e = 0; e < 4; e++) if (s_v[e] && s_la[e] == a[31:5]) j = e;
         if (j >= 0) begin
            kind = 1;
            s_v[j] = m_v[ix]; s_la[j] = {m_t[ix], ix};
         end else begin
            kind = 2;
            if (m_v[ix]) begin
               s_v[s_ptr] = 1; s_la[s_ptr] = {m_t[ix], ix}; s_ptr = (s_ptr + 1) % 4;
            end
         end
         m_v[ix] = 1; m_t[ix] = tg;
      end
   endtask

   task automatic access(input logic [31:0] a, input bit poke);
      int kind, n, f0;
      string rq;
      model_step(a, kind);
      rq = (kind == 0) ? "R3" : (kind == 1) ? "R6" : "R4";
      f0 = fills;
      @(negedge clk); req_valid = 1'b1; req_addr = a;
      @(negedge clk);
      if (poke) begin
         req_addr = a ^ 32'h0000_4000;
         chk(req_ready == 1'b0, "R9 busy ready", 32'(req_ready), 32'd0);
      end else req_valid = 1'b0;
      n = 0;
      while (!rsp_valid && n < 200) begin @(negedge clk); n++; end
      req_valid = 1'b0;
      if (!rsp_valid) begin
         chk(1'b0, {rq, " no response"}, 32'(n), 32'd0);
         return;
      end
      last_kind = rsp_hit ? 0 : rsp_side ? 1 : 2;
      chk(rsp_data == mem_word(a), {rq, " data R2"}, rsp_data, mem_word(a));
      chk(rsp_hit == (kind == 0) && rsp_side == (kind == 1), {rq, " source"},
          {30'd0, rsp_hit, rsp_side}, {30'd0, kind == 0, kind == 1});
      chk(!(rsp_hit && rsp_side), "R10 flags", {30'd0, rsp_hit, rsp_side}, 32'd0);
      chk((fills - f0) == ((kind == 2) ? 1 : 0), {rq, " fetch count"},
          32'(fills - f0), (kind == 2) ? 32'd1 : 32'd0);
      if (kind == 2)
         chk(last_fill_addr == {a[31:5], 5'd0}, "R4 fetch addr", last_fill_addr, {a[31:5], 5'd0});
      if (kind == 0) chk(n == 1, "R3 latency", 32'(n), 32'd1);
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R10 pulse", 32'(rsp_valid), 32'd0);
   endtask

   task automatic expect_kind(input logic [31:0] a, input int kind, input string req);
      access(a, 1'b0);
      chk(last_kind == kind, req, 32'(last_kind), 32'(kind));
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   endtask

   // next-level memory: two idle cycles, then 8 beats
   initial begin
      forever begin
         @(negedge clk);
         if (mem_req) begin
            logic [31:0] fa;
            fa = mem_addr;
            last_fill_addr = fa;
            fills++;
            repeat (2) @(negedge clk);
            for (int b = 0; b < 8; b++) begin
               mem_rvalid = 1'b1;
               mem_rdata  = mem_word({fa[31:5], 3'(b), 2'b00});
               @(negedge clk);
            end
            mem_rvalid = 1'b0;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 32; i++) begin m_v[i] = 0; m_t[i] = '0; end
      for (int e = 0; e < 4; e++) begin s_v[e] = 0; s_la[e] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
      chk(rsp_valid == 1'b0, "R1 no response", 32'(rsp_valid), 32'd0);
      expect_kind(mk(5, 9, 12), 2, "R1 cold miss");
      // R2 word select and tag field
      expect_kind(mk(5, 9, 28), 0, "R2 other word same line");
      expect_kind(mk(5, 9, 1), 0, "R2 byte bits ignored");
      expect_kind(mk(6, 9, 0), 2, "R2 tag differs");
      // R5 evicted line was kept, R6 swap back
      expect_kind(mk(5, 9, 4), 1, "R5 evicted line in side buffer");
      // R8 ping-pong on index 3
      expect_kind(mk(1, 3, 0), 2, "R8 first miss");
      expect_kind(mk(2, 3, 8), 2, "R8 second miss");
      for (int k = 0; k < 6; k++)
         expect_kind(mk(1 + (k % 2), 3, 4 * k), 1, "R8 alternating side hit");
      // R9 request held during a burst
      access(mk(9, 20, 16), 1'b1);
      expect_kind(mk(9, 20, 16), 0, "R9 held request left no trace");
      // R7 FIFO overwrite on index 7
      for (int t = 1; t <= 6; t++) expect_kind(mk(t, 7, 0), 2, "R7 fill sequence");
      expect_kind(mk(1, 7, 0), 2, "R7 oldest overwritten");
      expect_kind(mk(3, 7, 0), 1, "R7 younger entry kept");
      // constrained random mix
      for (int i = 0; i < 700; i++) begin
         logic [31:0] a;
         a = mk(int'($urandom % 6), int'($urandom % 8), int'($urandom % 32));
         access(a, ($urandom % 16) == 0);
      end
      finish_run();
   end
endmodule